// File: doc/BRIEF.md
# Reset Sequencing Controller

This block merges the chip's reset requests into one internal system reset and one separate debug-logic reset. There are three sources: an active-low reset pin, a power-on indication from the supply monitor, and a brown-out detector output. The brown-out source counts only after software has enabled it. The power-on indication is the block's own asynchronous reset. The pin goes through a synchronizer that asserts at once and releases on the clock edge.

The system reset stays asserted while any source is requesting it. After the last request goes away, a settle counter runs for `SETTLE_CYCLES` clocks so that the oscillator has time to stabilise. If a new request arrives during that count, the count starts again from zero. When the count finishes, the system reset drops in one step. The debug reset is driven only by the power-on sequence: it rises with power-on and falls when that first sequence ends. Pin and brown-out resets do not touch it.

A small register port holds two things. One is the brown-out enable bit, which power-on and brown-out resets both clear. The other is a set of sticky cause flags that software clears by writing ones.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `por_req` is high, `sys_rst` and `dbg_rst` are high. When `por_req` falls with the pin high, `sys_rst` falls on the (SETTLE_CYCLES+2)th rising edge after the fall. Two of those edges come from the synchronizer.
- R2: Release waits for the later of power-on and pin. If the pin is still low when `por_req` falls, `sys_rst` stays high, and it falls on the (SETTLE_CYCLES+2)th edge after the pin rises.
- R3: After release, a low pin raises `sys_rst` by the next rising edge. After the pin rises again, `sys_rst` falls on the (SETTLE_CYCLES+2)th edge.
- R4: A request that arrives during the settle count restarts the count from zero, and `sys_rst` stays high throughout.
- R5: `dbg_rst` is high from power-on until the end of the first release. Pin and brown-out resets never raise it, and `dbg_rst` high implies `sys_rst` high.
- R6: Register address 0, bit 0 is the brown-out enable. It reads 0 after power-on. While it is 0, `brownout_det` has no effect on `sys_rst` or on the cause flags.
- R7: When the enable is 1 and `brownout_det` goes high, `sys_rst` rises on the 3rd edge and falls SETTLE_CYCLES edges later. The enable reads 0 afterwards, and a `brownout_det` that stays high then has no further effect.
- R8: Register address 1 holds the cause flags: bit 0 power-on, bit 1 pin, bit 2 brown-out, bit 3 reads 0. Power-on leaves the value 0001. A pin assertion sets bit 1 and a brown-out reset sets bit 2.
- R9: A write to address 1 clears each flag whose data bit is 1 and leaves the others. A write to address 0 loads the enable from data bit 0.
- R10: Once released, `sys_rst` rises again only after a request was present at the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator clock |
| por_req | input | 1 | Power-on indication, active high, asynchronous |
| ext_rst_n | input | 1 | Reset pin, active low, asynchronous |
| brownout_det | input | 1 | Brown-out detector output, active high, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enable, 1 cause flags |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data for `reg_addr`, combinational |
| sys_rst | output | 1 | Internal system reset, active high |
| dbg_rst | output | 1 | Debug-logic reset, active high |

## Verification
Any fault in the settle counter or in the synchronizer depth shows up as a release edge on `sys_rst` that is early or late by whole cycles, so the bench counts edges exactly instead of allowing slack. A brown-out enable that does not clear itself shows up within a few cycles after release, as a second `sys_rst` pulse while `brownout_det` is still high. Mistakes in the flag logic show up on the next read of address 1, and a `dbg_rst` path tied to the wrong source shows up on the first pin reset.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int CAUSE_W   = 3;
  localparam int CAUSE_POR = 0;
  localparam int CAUSE_PIN = 1;
  localparam int CAUSE_BOR = 2;
  localparam int REG_W     = 4;

  // terminal value of the settle counter for a given settle length
  function automatic int settle_last(input int cycles);
    return (cycles > 0) ? cycles - 1 : 0;
  endfunction

  // sticky flag update: set wins over write-one-to-clear
  function automatic logic [CAUSE_W-1:0] cause_next(
    input logic [CAUSE_W-1:0] cur,
    input logic [CAUSE_W-1:0] set,
    input logic [CAUSE_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= {STAGES{RST_VAL}};
    else      chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_count.sv
module rstseq_count
  import rstseq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 750000
) (
  input  logic clk,
  input  logic por_req,
  input  logic any_req,
  output logic sys_rst,
  output logic settle_done
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(settle_last(SETTLE_CYCLES));

  logic [CNT_W-1:0] cnt;

  assign settle_done = sys_rst && !any_req && (cnt == LAST);

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      sys_rst <= 1'b1;
      cnt     <= '0;
    end else if (any_req) begin
      sys_rst <= 1'b1;
      cnt     <= '0;
    end else if (settle_done) begin
      sys_rst <= 1'b0;
      cnt     <= '0;
    end else if (sys_rst) begin
      cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rstseq_regs.sv
module rstseq_regs
  import rstseq_pkg::*;
(
  input  logic               clk,
  input  logic               por_req,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic               pin_rise,
  input  logic               bor_fire,
  output logic               bor_en,
  output logic [CAUSE_W-1:0] cause,
  output logic [REG_W-1:0]   reg_rdata
);
  logic [CAUSE_W-1:0] set_v, clr_v;

  always_comb begin
    set_v            = '0;
    set_v[CAUSE_PIN] = pin_rise;
    set_v[CAUSE_BOR] = bor_fire;
    clr_v = (reg_wr && reg_addr) ? reg_wdata[CAUSE_W-1:0] : '0;
  end

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      bor_en <= 1'b0;
      cause  <= CAUSE_W'(1) << CAUSE_POR;
    end else begin
      if (bor_fire)                 bor_en <= 1'b0;
      else if (reg_wr && !reg_addr) bor_en <= reg_wdata[0];
      cause <= cause_next(cause, set_v, clr_v);
    end
  end

  always_comb begin
    if (reg_addr) reg_rdata = {{(REG_W-CAUSE_W){1'b0}}, cause};
    else          reg_rdata = {{(REG_W-1){1'b0}}, bor_en};
  end
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 750000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             por_req,
  input  logic             ext_rst_n,
  input  logic             brownout_det,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             sys_rst,
  output logic             dbg_rst
);
  logic pin_arst, pin_ok, pin_req, pin_req_q, pin_rise;
  logic bod_s, bor_en, bor_req, bor_fire, any_req, settle_done;
  logic por_phase;
  logic [CAUSE_W-1:0] cause;

  assign pin_arst = por_req | ~ext_rst_n;

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .arst(pin_arst), .d(1'b1), .q(pin_ok));

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bod_sync (
    .clk(clk), .arst(por_req), .d(brownout_det), .q(bod_s));

  assign pin_req  = ~pin_ok;
  assign bor_req  = bod_s & bor_en;
  assign bor_fire = bor_req;
  assign any_req  = pin_req | bor_req;
  assign pin_rise = pin_req & ~pin_req_q;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      pin_req_q <= 1'b1;
      por_phase <= 1'b1;
    end else begin
      pin_req_q <= pin_req;
      if (settle_done) por_phase <= 1'b0;
    end
  end

  rstseq_count #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_count (
    .clk(clk), .por_req(por_req), .any_req(any_req),
    .sys_rst(sys_rst), .settle_done(settle_done));

  rstseq_regs u_regs (
    .clk(clk), .por_req(por_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pin_rise(pin_rise), .bor_fire(bor_fire),
    .bor_en(bor_en), .cause(cause), .reg_rdata(reg_rdata));

  assign dbg_rst = por_phase;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk
  import rstseq_pkg::*;
(
  input logic               clk,
  input logic               por_req,
  input logic               any_req,
  input logic               sys_rst,
  input logic               dbg_rst,
  input logic               bor_fire,
  input logic               bor_en,
  input logic               pin_rise,
  input logic [CAUSE_W-1:0] cause
);
  // R3
  req_holds_rst_chk: assert property (@(posedge clk) disable iff (por_req)
    any_req |=> sys_rst);

  // R5
  dbg_within_sys_chk: assert property (@(posedge clk) disable iff (por_req)
    dbg_rst |-> sys_rst);

  // R5
  dbg_no_rise_chk: assert property (@(posedge clk) disable iff (por_req)
    !$rose(dbg_rst));

  // R7
  bor_en_drops_chk: assert property (@(posedge clk) disable iff (por_req)
    bor_fire |=> !bor_en);

  // R8
  pin_flag_chk: assert property (@(posedge clk) disable iff (por_req)
    pin_rise |=> cause[CAUSE_PIN]);

  // R8
  bor_flag_chk: assert property (@(posedge clk) disable iff (por_req)
    bor_fire |=> cause[CAUSE_BOR]);

  // R10
  rst_rise_cause_chk: assert property (@(posedge clk) disable iff (por_req)
    $rose(sys_rst) |-> $past(any_req));

  // R4
  release_quiet_chk: assert property (@(posedge clk) disable iff (por_req)
    $fell(sys_rst) |-> $past(!any_req));
endmodule

bind rstseq_ctrl rstseq_chk u_chk (
  .clk(clk), .por_req(por_req), .any_req(any_req), .sys_rst(sys_rst),
  .dbg_rst(dbg_rst), .bor_fire(bor_fire), .bor_en(bor_en),
  .pin_rise(pin_rise), .cause(cause));

// File: tb/rstseq_ctrl_bench.sv
module rstseq_ctrl_bench;
  localparam int N = 20;
  localparam int NV = 6;

  logic clk = 1'b0;
  logic por_req = 1'b1, ext_rst_n = 1'b1, brownout_det = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [3:0] reg_wdata = '0, reg_rdata;
  logic sys_rst, dbg_rst;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rstseq_ctrl #(.SETTLE_CYCLES(N)) u_rstseq_ctrl (
    .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n),
    .brownout_det(brownout_det), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_rst(sys_rst), .dbg_rst(dbg_rst));

  // vector: {addr, wdata, expected read of same addr afterwards} (R9)
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 4'b0010, 4'b0101},
    {1'b1, 4'b0000, 4'b0101},
    {1'b1, 4'b0101, 4'b0000},
    {1'b0, 4'b0001, 4'b0001},
    {1'b0, 4'b1110, 4'b0000},
    {1'b1, 4'b0111, 4'b0000}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // edges until sys_rst low, counted from a negedge
  task automatic edges_to_release(output int n);
    n = 0;
    while (sys_rst && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic rd(input logic a, output logic [3:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [3:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    logic [3:0] v;
    cyc(3);
    // R1 reset state
    check("R1 sys_rst during por", sys_rst, 1);
    check("R5 dbg_rst during por", dbg_rst, 1);
    por_req = 1'b0;
    edges_to_release(n);
    check("R1 release edges", n, N + 2);
    check("R5 dbg_rst after release", dbg_rst, 0);
    rd(1'b1, v); check("R8 flags after por", v, 4'b0001);
    rd(1'b0, v); check("R6 enable after por", v, 0);

    // R2 pin held past por
    por_req = 1'b1; ext_rst_n = 1'b0; cyc(2);
    por_req = 1'b0; cyc(N + 10);
    check("R2 held by pin", sys_rst, 1);
    check("R2 dbg held", dbg_rst, 1);
    ext_rst_n = 1'b1;
    edges_to_release(n);
    check("R2 release edges", n, N + 2);
    rd(1'b1, v); check("R8 pin during por sets no flag", v, 4'b0001);

    // R3 pin reset
    cyc(4); ext_rst_n = 1'b0; cyc(1);
    check("R3 assert next edge", sys_rst, 1);
    cyc(3);
    check("R5 pin leaves dbg low", dbg_rst, 0);
    ext_rst_n = 1'b1;
    edges_to_release(n);
    check("R3 release edges", n, N + 2);
    rd(1'b1, v); check("R8 pin flag", v, 4'b0011);

    // R4 restart during settle
    ext_rst_n = 1'b0; cyc(2); ext_rst_n = 1'b1; cyc(N / 2);
    check("R4 still held mid-count", sys_rst, 1);
    ext_rst_n = 1'b0; cyc(1); ext_rst_n = 1'b1;
    edges_to_release(n);
    check("R4 release after restart", n, N + 2);

    // R6 brown-out ignored while disabled
    cyc(3); brownout_det = 1'b1;
    begin
      int hits = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (sys_rst) hits++; end
      check("R6 disabled brown-out ignored", hits, 0);
    end
    rd(1'b1, v); check("R6 no flag when disabled", v, 4'b0011);
    brownout_det = 1'b0; cyc(4);

    // R7 enabled brown-out
    wr(1'b0, 4'b0001);
    rd(1'b0, v); check("R9 enable write", v, 1);
    brownout_det = 1'b1;
    n = 0;
    while (!sys_rst && n < 50) begin @(negedge clk); n++; end
    check("R7 assert edge", n, 3);
    edges_to_release(n);
    check("R7 release edges", n, N);
    begin
      int hits = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (sys_rst) hits++; end
      check("R7 held detector ignored after", hits, 0);
    end
    check("R5 brown-out leaves dbg low", dbg_rst, 0);
    rd(1'b0, v); check("R7 enable cleared", v, 0);
    rd(1'b1, v); check("R8 brown-out flag", v, 4'b0111);
    brownout_det = 1'b0;

    // R9 register vectors
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][8], VEC[k][7:4]);
      rd(VEC[k][8], v);
      check($sformatf("R9 vector %0d", k), v, VEC[k][3:0]);
    end
    check("R10 stays released", sys_rst, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule